// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from a set of peripheral ports and one non-maskable source. It presents a single registered interrupt request line to a processor. Each request input is sampled every cycle and held in a sticky pending bit. A priority resolver looks at the pending bits and picks a winner. Maskable sources are gated by a global enable bit and by a programmable priority threshold; the non-maskable source bypasses both and beats every maskable one.

The processor answers the request line with an acknowledge pulse. On the clock edge that samples the acknowledge, the controller does four things:
- it captures a vector that depends only on the winning priority level;
- it clears that source's pending bit;
- it clears the global enable, so no further maskable request is forwarded until software sets the enable again;
- it drops the request line.

Requests that arrive while enable is off, or while they sit under the threshold, stay pending until they become eligible. A small register port gives software access to the enable, the threshold and the pending bits. Software can also discard a pending request by writing a one to its bit.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request line is 0, the vector-valid flag is 0, and the enable, threshold, maskable pending bits and non-maskable pending bit all read 0.
- R2: An `irq_in[i]` or `nmi_in` that is high at a clock edge sets the matching pending bit at that edge. Register address 2 reads the maskable pending bits, bit i for source i. Address 3 bit 0 reads the non-maskable pending bit.
- R3: Source i has priority level i+1. Among eligible pending maskable sources, the one with the highest index wins.
- R4: A maskable source of level L is eligible only when L is strictly greater than the threshold. The threshold is held at register address 1, bits [3:0]. A threshold of 8 blocks all maskable sources.
- R5: Maskable sources are forwarded only while the enable bit is 1. The enable bit is register address 0, bit 0.
- R6: The non-maskable source raises the request regardless of enable and threshold. When it is pending, it wins over every maskable source.
- R7: `int_req` is registered. It rises on the clock edge after the one at which the winning source became pending and eligible.
- R8: `vec_valid` is 1 for exactly the cycle after each sampled acknowledge. In that cycle `vec_out` is 0x40 + L for a maskable winner of level L, and 0x49 for the non-maskable source.
- R9: At a sampled acknowledge, the winner's pending bit clears, the enable bit clears and the request line falls on the same edge.
- R10: An acknowledge with no eligible winner returns vector 0x40 and leaves all pending bits unchanged.
- R11: Writing 1 to a bit at address 2 (or to bit 0 at address 3) clears that pending bit. A request that stays pending while disabled raises `int_req` once enable is set again.
- R12: `reg_rdata` shows the register selected by `reg_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Maskable request inputs, source 0 lowest |
| nmi_in | input | 1 | Non-maskable request input |
| int_ack | input | 1 | Acknowledge from the processor |
| int_req | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Vector captured at acknowledge |
| vec_valid | output | 1 | Vector valid strobe, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 threshold, 2 pending, 3 non-maskable pending |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is an acknowledge taken while other requests are still pending but ineligible. The winner must leave and the others must stay. The bench reaches this by sweeping every pending pattern against every threshold. In each case it clears state, programs the threshold, enables, pulses the pattern in a single cycle and then acknowledges. Afterwards it reads the pending register back, so both removal of the winner and retention of the losers are checked at the ports. Directed sequences then mix the non-maskable input with a pending maskable source while enable is off, and re-enable afterwards to show the held request coming back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_PEND = 2'd2,
    RA_NMI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= req_in[i] | (pend[i] & ~clr[i]);
    end

    // R2: a sampled request always lands in its pending bit
    a_r2_sets: assert property (@(posedge clk) disable iff (rst)
      req_in[i] |=> pend[i]);
    // R9/R11: a clear without a fresh request empties the bit
    a_r9_clears: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !req_in[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int N  = 8,
  parameter int LW = 4
) (
  input  logic [N-1:0]  pend,
  input  logic          nmi_pend,
  input  logic          enable,
  input  logic [LW-1:0] thresh,
  output logic [N-1:0]  grant,
  output logic          nmi_sel,
  output logic          any,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] NMI_LVL = LW'(N + 1);

  logic [N-1:0] elig;

  for (genvar i = 0; i < N; i++) begin : g_elig
    assign elig[i] = pend[i] & enable & (LW'(i + 1) > thresh);
  end

  always_comb begin
    grant   = '0;
    level   = '0;
    nmi_sel = nmi_pend;
    if (nmi_pend) begin
      level = NMI_LVL;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (elig[i]) begin
          grant = '0;
          grant[i] = 1'b1;
          level = LW'(i + 1);
        end
      end
    end
    any = nmi_pend | (|elig);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N        = 8,
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          nmi_in,
  input  logic          int_ack,
  output logic          int_req,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  import irqc_pkg::*;

  localparam int LW = $clog2(N + 2);
  localparam logic [VW-1:0] NMI_VEC = VW'(VEC_BASE + N + 1);

  logic          en_q, nmi_pend_q, int_req_q, vec_vld_q;
  logic [LW-1:0] mask_q;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] rdata_q;
  logic [N-1:0]  pend, grant, clr;
  logic          nmi_sel, any_elig, nmi_clr;
  logic [LW-1:0] win_lvl;
  reg_addr_e     addr;

  assign addr = reg_addr_e'(reg_addr);

  assign clr = ((reg_wr && addr == RA_PEND) ? reg_wdata[N-1:0] : '0)
             | (int_ack ? grant : '0);
  assign nmi_clr = (reg_wr && addr == RA_NMI && reg_wdata[0]) | (int_ack & nmi_sel);

  irqc_pend_bank #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .req_in(irq_in), .clr(clr), .pend(pend)
  );

  irqc_resolver #(.N(N), .LW(LW)) u_res (
    .pend(pend), .nmi_pend(nmi_pend_q), .enable(en_q), .thresh(mask_q),
    .grant(grant), .nmi_sel(nmi_sel), .any(any_elig), .level(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      mask_q     <= '0;
      nmi_pend_q <= 1'b0;
      int_req_q  <= 1'b0;
      vec_q      <= '0;
      vec_vld_q  <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (int_ack)                        en_q <= 1'b0;
      else if (reg_wr && addr == RA_CTRL) en_q <= reg_wdata[0];
      if (reg_wr && addr == RA_MASK) mask_q <= reg_wdata[LW-1:0];
      nmi_pend_q <= nmi_in | (nmi_pend_q & ~nmi_clr);
      int_req_q  <= any_elig & ~int_ack;
      vec_vld_q  <= int_ack;
      if (int_ack) vec_q <= VW'(VEC_BASE) + VW'(win_lvl);
      case (addr)
        RA_CTRL: rdata_q <= DW'(en_q);
        RA_MASK: rdata_q <= DW'(mask_q);
        RA_PEND: rdata_q <= DW'(pend);
        default: rdata_q <= DW'(nmi_pend_q);
      endcase
    end
  end

  assign int_req   = int_req_q;
  assign vec_out   = vec_q;
  assign vec_valid = vec_vld_q;
  assign reg_rdata = rdata_q;

  // R9: acknowledge turns the global enable off
  a_r9_ack_disables: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !en_q);
  // R8: one strobe per acknowledge
  a_r8_strobe: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> vec_valid);
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !int_ack |=> !vec_valid);
  // R6: non-maskable source takes the acknowledge
  a_r6_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    (int_ack && nmi_pend_q) |=> (vec_out == NMI_VEC));
  // R7: the line only rises behind an eligible source
  a_r7_req_cause: assert property (@(posedge clk) disable iff (rst)
    int_req |-> $past(any_elig));
  // R5: disabled and no non-maskable source keeps the line low
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !nmi_pend_q) |=> !int_req);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       nmi_in = 1'b0, int_ack = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       int_req, vec_valid;
  logic [7:0] vec_out, reg_rdata;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .nmi_in(nmi_in), .int_ack(int_ack),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 2'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic ack();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 int_req", int'(int_req), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
    rd(0, d); chk("R1 enable", d, 0);
    rd(1, d); chk("R1 threshold", d, 0);
    rd(2, d); chk("R1 pending", d, 0);
    rd(3, d); chk("R1 nmi pending", d, 0);

    // Sweep: every threshold, every pattern (R2 R3 R4 R7 R8 R9 R10 R12)
    for (int m = 0; m <= 8; m++) begin
      for (int p = 0; p < 256; p++) begin
        int w, ev, ep;
        w = -1;
        for (int i = 0; i < 8; i++) if (p[i] && (i + 1) > m) w = i;
        ev = 8'h40 + w + 1;
        ep = (w >= 0) ? (p & ~(1 << w)) : p;
        wr(1, m);
        wr(2, 8'hFF);
        wr(0, 1);
        irq_in = 8'(p);
        @(negedge clk);
        irq_in = '0;
        chk("R7 not yet", int'(int_req), 0);
        @(negedge clk);
        chk("R4/R3 int_req", int'(int_req), (w >= 0) ? 1 : 0);
        rd(2, d); chk("R2/R12 pending", d, p);
        ack();
        chk("R8 vec_valid", int'(vec_valid), 1);
        chk((w >= 0) ? "R3/R8 vector" : "R10 spurious vector", int'(vec_out), ev);
        chk("R9 req drop", int'(int_req), 0);
        rd(2, d); chk((w >= 0) ? "R9 pending after" : "R10 pending kept", d, ep);
        chk("R8 strobe single", int'(vec_valid), 0);
        rd(0, d); chk("R9 enable cleared", d, 0);
      end
    end

    // R6: non-maskable source with enable off and full threshold
    wr(2, 8'hFF);
    wr(1, 8);
    irq_in = 8'h80; nmi_in = 1'b1;
    @(negedge clk);
    irq_in = '0; nmi_in = 1'b0;
    @(negedge clk);
    chk("R6 nmi req", int'(int_req), 1);
    rd(3, d); chk("R2 nmi pending", d, 1);
    ack();
    chk("R6 nmi vector", int'(vec_out), 8'h49);
    rd(3, d); chk("R9 nmi cleared", d, 0);
    rd(2, d); chk("R11 held pending", d, 8'h80);
    // R11: held request returns after re-enable once threshold allows it
    wr(1, 0);
    @(negedge clk);
    chk("R5 disabled quiet", int'(int_req), 0);
    wr(0, 1);
    @(negedge clk);
    chk("R11 re-enable raises", int'(int_req), 1);
    // R6: nmi beats a pending enabled source
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
    ack();
    chk("R6 nmi outranks", int'(vec_out), 8'h49);
    rd(2, d); chk("R6 maskable untouched", d, 8'h80);
    // R11: write-one-to-clear
    wr(0, 1);
    wr(2, 8'h80);
    @(negedge clk);
    rd(2, d); chk("R11 w1c pending", d, 0);
    chk("R11 w1c req low", int'(int_req), 0);
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
    wr(3, 1);
    rd(3, d); chk("R11 w1c nmi", d, 0);
    finish_run();
  end
endmodule